// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small microcontroller core runs, idles or stops. Software writes a two-bit mode register. Bit 0 requests idle and bit 1 requests stop. The request is held until the CPU reports, through an instruction-complete strobe, that the writing instruction has retired. Only then is the CPU clock gated off.

In idle the oscillator and the peripheral clocks keep running, and an interrupt request brings the core back. In stop the oscillator itself is switched off, and only a reset can end it.

The block also gathers the chip's reset sources into one core reset and keeps a sticky record of which sources caused it. There are four sources:
- an external reset request
- a missing-clock detector
- a comparator trip
- an external convert-start strobe

The missing-clock detector runs from an independent, always-on reference clock. It watches for edges of the system clock. If none arrive for a parameterised number of reference ticks, it raises a reset. A stop entered with the detector enabled is therefore ended by the detector itself. Software must turn the detector off before entering stop if the core is meant to stay stopped. When the core leaves reset it fetches from address 0x0000; that is the CPU's job once `core_rst` falls.

All interfaces are plain control and status pins. No data streams through the block, so there is no valid/ready handshake. The external reset, comparator and convert-start inputs are levels, synchronous to `clk`. They must be held for at least two cycles of the running clock so that they are captured after a wake from stop.

Top module: `pwr_state_ctrl`

## Requirements
- R1: `pcon_rdata` reports the mode register. Bit 0 is the idle request and bit 1 is the stop request. A write (`pcon_we`) while running updates it at the next `clk` edge.
- R2: A mode request takes effect only at the edge where `instr_done` is high, and that may be the same edge as the write. Until that edge `cpu_clk_en` stays 1. From the cycle after it, `cpu_clk_en` is 0.
- R3: In idle, `cpu_clk_en` is 0 and `osc_en` is 1.
- R4: In idle, an `irq` at a clock edge returns the core to run and clears mode bit 0. In the following cycle `cpu_clk_en` is 1 and `wake` is 1; `wake` falls one cycle later. An `irq` while running changes nothing, and `wake` stays 0.
- R5: In stop, `cpu_clk_en` and `osc_en` are both 0, and an `irq` has no effect.
- R6: If a request has both bits set (value 3), the core enters stop rather than idle.
- R7: In the cycle after any reset source is seen at an edge, `core_rst` is 1, the mode register reads 0 and the core is in run. `core_rst` falls in the cycle after an edge where no source is active.
- R8: In stop, `osc_en` returns to 1 in the same cycle that any reset source becomes active, without waiting for a clock edge.
- R9: `rst_cause` is 0 after power-on. Bit 0 is external, bit 1 is missing clock, bit 2 is comparator and bit 3 is convert-start. On the first edge of a reset event it is loaded with the active sources. Sources that join while the event lasts are ORed in. The value is held after the event ends.
- R10: With `mcd_en` high, once `clk` has had no edges for `MCD_TIMEOUT` reference ticks, a reset with cause bit 1 is raised. With `mcd_en` low, stop persists indefinitely. With the clock running, the detector never fires.
- R11: Mode writes while the core is idle are ignored: the mode register and `osc_en` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (stops when `osc_en` is low) |
| ref_clk | input | 1 | Free-running reference clock for the missing-clock detector |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pcon_we | input | 1 | Mode register write strobe |
| pcon_wdata | input | 2 | Mode register write value (bit 0 idle, bit 1 stop) |
| instr_done | input | 1 | Current CPU instruction has retired |
| irq | input | 1 | Enabled interrupt request |
| mcd_en | input | 1 | Missing-clock detector enable |
| ext_rst_req | input | 1 | External reset request |
| cmp_trip | input | 1 | Comparator trip reset request |
| cnv_start | input | 1 | External convert-start reset request |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| wake | output | 1 | One-cycle pulse on leaving idle by interrupt |
| core_rst | output | 1 | Core reset, active high |
| pcon_rdata | output | 2 | Mode register read value |
| rst_cause | output | 4 | Sticky reset-source record |

## Verification
The bench sweeps every mode value in two cases: written together with `instr_done`, and written ahead of it. A controller that gated the clock on the write alone, or that picked idle when both bits are set, shows the wrong `cpu_clk_en` or `osc_en`.

The bench also sweeps every combination of the synchronous reset sources from run, from idle and from stop. A design that needs a clock edge to restart the oscillator stays dark forever. A design that overwrites the cause record mid-event loses bits.

The missing-clock detector is tested three ways: disabled in stop, where a wrong design wakes spuriously; enabled in stop, where a wrong design never wakes; and enabled with the clock running, where a wrong design raises false resets.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_IDLE = 2'd1,
    PS_STOP = 2'd2
  } pwr_state_e;

  localparam int MODE_W    = 2;
  localparam int IDLE_BIT  = 0;
  localparam int STOP_BIT  = 1;
  localparam int NSRC      = 4;
  localparam int SRC_EXT   = 0;
  localparam int SRC_MCD   = 1;
  localparam int SRC_CMP   = 2;
  localparam int SRC_CNV   = 3;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              src_any,
  input  logic              pcon_we,
  input  logic [MODE_W-1:0] pcon_wdata,
  input  logic              instr_done,
  input  logic              irq,
  output logic              cpu_clk_en,
  output logic              run_osc_en,
  output logic              wake,
  output logic [MODE_W-1:0] pcon_rdata
);
  pwr_state_e        state_q, state_d;
  logic [MODE_W-1:0] pcon_q, pcon_d, eff_mode;
  logic              wake_q, wake_d;

  always_comb begin
    state_d  = state_q;
    pcon_d   = pcon_q;
    wake_d   = 1'b0;
    eff_mode = pcon_q;
    if (state_q == PS_RUN && pcon_we) begin
      pcon_d   = pcon_wdata;
      eff_mode = pcon_wdata;
    end
    case (state_q)
      PS_RUN: begin
        if (instr_done) begin
          if (eff_mode[STOP_BIT])      state_d = PS_STOP;
          else if (eff_mode[IDLE_BIT]) state_d = PS_IDLE;
        end
      end
      PS_IDLE: begin
        if (irq) begin
          state_d          = PS_RUN;
          pcon_d[IDLE_BIT] = 1'b0;
          wake_d           = 1'b1;
        end
      end
      default: ;
    endcase
    if (src_any) begin
      state_d = PS_RUN;
      pcon_d  = '0;
      wake_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= PS_RUN;
      pcon_q  <= '0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pcon_q  <= pcon_d;
      wake_q  <= wake_d;
    end
  end

  assign cpu_clk_en = (state_q == PS_RUN);
  assign run_osc_en = (state_q != PS_STOP);
  assign wake       = wake_q;
  assign pcon_rdata = pcon_q;

  // R2
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_clk_en && !instr_done && !src_any) |=> cpu_clk_en);
  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PS_IDLE && irq && !src_any) |=> (cpu_clk_en && wake && !pcon_rdata[IDLE_BIT]));
  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PS_STOP && !src_any) |=> (state_q == PS_STOP));
  // R6
  stop_prio_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PS_RUN && instr_done && pcon_we && pcon_wdata == 2'b11 && !src_any)
      |=> !run_osc_en);
  // R7
  rst_clears_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
    src_any |=> (cpu_clk_en && pcon_rdata == '0 && !wake));
  // R11
  idle_write_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == PS_IDLE && !irq && !src_any) |=> $stable(pcon_rdata));
endmodule

// File: rtl/pwr_rst_collect.sv
module pwr_rst_collect
  import pwr_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic [NSRC-1:0] src,
  output logic            src_any,
  output logic            core_rst,
  output logic [NSRC-1:0] cause
);
  logic            rst_q;
  logic [NSRC-1:0] cause_q;

  assign src_any = |src;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      rst_q <= src_any;
      if (src_any) cause_q <= rst_q ? (cause_q | src) : src;
    end
  end

  assign core_rst = rst_q;
  assign cause    = cause_q;

  // R7
  core_rst_follows_chk: assert property (@(posedge clk) disable iff (!por_n)
    src_any |=> core_rst);
  // R9
  cause_recorded_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |-> (cause != '0));
  // R9
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (core_rst && src_any) |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/pwr_clk_monitor.sv
module pwr_clk_monitor #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic ref_clk,
  input  logic por_n,
  input  logic en,
  output logic fire_ref,
  output logic fire_sync
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          beat_q;
  logic [2:0]    beat_s;
  logic [1:0]    en_s;
  logic [CW-1:0] cnt_q;
  logic          fire_q;
  logic [1:0]    fire_s;
  logic          beat_seen;

  // heartbeat toggles on every system clock edge
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) beat_q <= 1'b0;
    else        beat_q <= ~beat_q;
  end

  assign beat_seen = beat_s[2] ^ beat_s[1];

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) begin
      beat_s <= '0;
      en_s   <= '0;
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      beat_s <= {beat_s[1:0], beat_q};
      en_s   <= {en_s[0], en};
      if (beat_seen)           cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      fire_q <= en_s[1] && (cnt_q == LIMIT);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) fire_s <= '0;
    else        fire_s <= {fire_s[0], fire_q};
  end

  assign fire_ref  = fire_q;
  assign fire_sync = fire_s[1];

  // R10
  mcd_quiet_after_edge_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    beat_seen |=> ##1 !fire_q);
  // R10
  mcd_disabled_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    (!en_s[1]) |=> !fire_ref);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int MCD_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              ref_clk,
  input  logic              por_n,
  input  logic              pcon_we,
  input  logic [MODE_W-1:0] pcon_wdata,
  input  logic              instr_done,
  input  logic              irq,
  input  logic              mcd_en,
  input  logic              ext_rst_req,
  input  logic              cmp_trip,
  input  logic              cnv_start,
  output logic              cpu_clk_en,
  output logic              osc_en,
  output logic              wake,
  output logic              core_rst,
  output logic [MODE_W-1:0] pcon_rdata,
  output logic [NSRC-1:0]   rst_cause
);
  logic            fire_ref, fire_sync, src_any, run_osc_en;
  logic [NSRC-1:0] src;

  pwr_clk_monitor #(.TIMEOUT(MCD_TIMEOUT)) u_mon (
    .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .en(mcd_en),
    .fire_ref(fire_ref), .fire_sync(fire_sync)
  );

  always_comb begin
    src          = '0;
    src[SRC_EXT] = ext_rst_req;
    src[SRC_MCD] = fire_sync;
    src[SRC_CMP] = cmp_trip;
    src[SRC_CNV] = cnv_start;
  end

  pwr_rst_collect u_rst (
    .clk(clk), .por_n(por_n), .src(src),
    .src_any(src_any), .core_rst(core_rst), .cause(rst_cause)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .por_n(por_n), .src_any(src_any),
    .pcon_we(pcon_we), .pcon_wdata(pcon_wdata), .instr_done(instr_done), .irq(irq),
    .cpu_clk_en(cpu_clk_en), .run_osc_en(run_osc_en), .wake(wake), .pcon_rdata(pcon_rdata)
  );

  // a reset source restarts the oscillator without needing a clock edge
  assign osc_en = run_osc_en | ext_rst_req | cmp_trip | cnv_start | fire_ref | fire_sync;
endmodule

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;
  localparam int TMO = 16;

  logic clk_raw = 1'b0, gate = 1'b1, ref_clk = 1'b0, clk;
  logic por_n = 1'b0, pcon_we = 1'b0, instr_done = 1'b0, irq = 1'b0, mcd_en = 1'b0;
  logic ext_rst_req = 1'b0, cmp_trip = 1'b0, cnv_start = 1'b0;
  logic [1:0] pcon_wdata = '0;
  logic cpu_clk_en, osc_en, wake, core_rst;
  logic [1:0] pcon_rdata;
  logic [3:0] rst_cause;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk_raw = ~clk_raw;
  always #3.5 ref_clk = ~ref_clk;
  always @(negedge clk_raw) gate <= osc_en;
  assign clk = clk_raw & gate;

  pwr_state_ctrl #(.MCD_TIMEOUT(TMO)) u_dut (
    .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
    .instr_done(instr_done), .irq(irq), .mcd_en(mcd_en), .ext_rst_req(ext_rst_req),
    .cmp_trip(cmp_trip), .cnv_start(cnv_start), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
    .wake(wake), .core_rst(core_rst), .pcon_rdata(pcon_rdata), .rst_cause(rst_cause)
  );

  task automatic tick();
    @(posedge clk_raw); #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_src(input logic [2:0] s);
    ext_rst_req = s[0]; cmp_trip = s[1]; cnv_start = s[2];
  endtask

  function automatic logic [3:0] cause_of(input logic [2:0] s);
    return {s[2], s[1], 1'b0, s[0]};
  endfunction

  task automatic ext_wake();
    ext_rst_req = 1'b1; #1;
    chk(osc_en, 1, "R8 osc restarts");
    repeat (3) tick();
    chk(core_rst, 1, "R7 core_rst"); chk(pcon_rdata, 0, "R7 mode cleared");
    ext_rst_req = 1'b0;
    repeat (2) tick();
    chk(core_rst, 0, "R7 core_rst release"); chk(rst_cause, 4'b0001, "R9 ext cause");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    por_n = 1'b1;
    tick();
    chk(cpu_clk_en, 1, "R2 reset run"); chk(osc_en, 1, "R3 reset osc");
    chk(core_rst, 0, "R7 reset"); chk(rst_cause, 0, "R9 por clears");
    chk(pcon_rdata, 0, "R1 reset"); chk(wake, 0, "R4 reset");

    // irq while running does nothing (R4)
    irq = 1'b1; tick(); irq = 1'b0;
    chk(cpu_clk_en, 1, "R4 irq in run"); chk(wake, 0, "R4 no wake in run");

    // sweep mode values, with and without a same-cycle retire (R1 R2 R3 R5 R6)
    for (int w = 0; w < 4; w++) begin
      for (int same = 0; same < 2; same++) begin
        pcon_we = 1'b1; pcon_wdata = 2'(w); instr_done = same[0];
        tick();
        pcon_we = 1'b0; instr_done = 1'b0;
        chk(pcon_rdata, 8'(w), "R1 readback");
        if (same == 0) begin
          repeat (2) tick();
          chk(cpu_clk_en, 1, "R2 waits for retire");
          instr_done = 1'b1; tick(); instr_done = 1'b0;
        end
        chk(cpu_clk_en, (w != 0) ? 0 : 1, "R2 gate after retire");
        chk(osc_en, (w >= 2) ? 0 : 1, "R3 R5 R6 osc state");
        if (w == 1) begin
          pcon_we = 1'b1; pcon_wdata = 2'b10; instr_done = 1'b1;
          tick();
          pcon_we = 1'b0; instr_done = 1'b0;
          chk(pcon_rdata, 1, "R11 write ignored in idle");
          chk(osc_en, 1, "R11 no stop from idle");
          irq = 1'b1; tick(); irq = 1'b0;
          chk(cpu_clk_en, 1, "R4 back to run"); chk(wake, 1, "R4 wake pulse");
          chk(pcon_rdata, 0, "R4 idle bit cleared");
          tick();
          chk(wake, 0, "R4 wake one cycle");
        end else if (w >= 2) begin
          irq = 1'b1; repeat (4) tick(); irq = 1'b0;
          chk(osc_en, 0, "R5 irq ignored in stop"); chk(cpu_clk_en, 0, "R5 cpu off");
          ext_wake();
        end
      end
    end

    // reset-source sweep from run, idle and stop (R7 R8 R9)
    for (int mode = 0; mode < 3; mode++) begin
      for (int s = 1; s < 8; s++) begin
        if (mode != 0) begin
          pcon_we = 1'b1; pcon_wdata = (mode == 1) ? 2'b01 : 2'b10; instr_done = 1'b1;
          tick(); pcon_we = 1'b0; instr_done = 1'b0;
        end
        set_src(3'(s)); #1;
        chk(osc_en, 1, "R8 osc on with source");
        repeat (3) tick();
        chk(core_rst, 1, "R7 reset asserted"); chk(pcon_rdata, 0, "R7 mode zero");
        chk(cpu_clk_en, 1, "R7 run in reset");
        chk(rst_cause, 8'(cause_of(3'(s))), "R9 cause load");
        set_src(3'b000); tick();
        chk(core_rst, 0, "R7 reset released");
        repeat (2) tick();
        chk(rst_cause, 8'(cause_of(3'(s))), "R9 cause held");
      end
    end

    // sources joining during an event are ORed in (R9)
    set_src(3'b001); tick(); set_src(3'b011); tick(); set_src(3'b110); tick();
    set_src(3'b000); tick();
    chk(rst_cause, 4'b1101, "R9 cause accumulates");

    // missing clock disabled: stop persists (R10)
    pcon_we = 1'b1; pcon_wdata = 2'b10; instr_done = 1'b1;
    tick(); pcon_we = 1'b0; instr_done = 1'b0;
    repeat (200) tick();
    chk(osc_en, 0, "R10 disabled stays stopped"); chk(core_rst, 0, "R10 no reset");
    ext_wake();

    // enabled with clock running: never fires (R10)
    mcd_en = 1'b1;
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 300; i++) begin tick(); if (core_rst) seen = 1'b1; end
      chk(seen, 0, "R10 no false fire");
    end

    // enabled in stop: detector wakes the core (R10)
    pcon_we = 1'b1; pcon_wdata = 2'b10; instr_done = 1'b1;
    tick(); pcon_we = 1'b0; instr_done = 1'b0;
    begin
      logic seen = 1'b0;
      for (int i = 0; i < 400 && !seen; i++) begin tick(); if (core_rst) seen = 1'b1; end
      chk(seen, 1, "R10 detector wakes stop");
      for (int i = 0; i < 100 && core_rst; i++) tick();
    end
    repeat (4) tick();
    chk(core_rst, 0, "R10 reset ends"); chk(rst_cause, 4'b0010, "R10 R9 mcd cause");
    chk(cpu_clk_en, 1, "R10 running again"); chk(osc_en, 1, "R10 osc on");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule